// File: doc/BRIEF.md
# Module Clock Stop Controller

This block owns the clock enables of a set of peripheral modules, up to 384 of them, grouped into banks. Each module has one stop bit. Software holds a module stopped by writing 1 to its bit and lets it run by writing 0. Bits are read and changed a whole word at a time, so software changes single modules by read-modify-write. Module number m lives in bank m/32 at bit m mod 32 in the default build.

Each module also has a handshake to its gate. The stop bit is the request. The acknowledge is a status bit that software reads at a second set of word addresses. The acknowledge rises one cycle after a stop request. After a run request it falls only once a settling delay of RUN_DELAY cycles has passed. Software waits for that bit to read 0 before it uses the module.

A build variant with WIDE_BANKS = 0 uses 8-bit banks and has no status view. In that variant software confirms a change by reading back the control word.

Top module: `modstop_gate_ctrl`

## Requirements
- R1: After synchronous reset every existing stop bit is 1. Every clk_en output is 0, and every existing status bit reads 1.
- R2: Module m is controlled by bit m mod 32 of the control word at word address m/32, with 1 = stopped and 0 = running. Control words sit at word addresses 0 to 11.
- R3: Every request presented while req_ready is high is answered by rsp_valid exactly one cycle later. A read returns the addressed word on rsp_rdata in that cycle. Writes replace the whole word.
- R4: clk_en for a module is the inverse of its stop bit and changes in the cycle after the write is accepted.
- R5: The status word for bank b is at word address 16+b. A status bit reads 1 starting from the second read issued after the stop write.
- R6: After a stop bit changes from 1 to 0, its status bit falls exactly RUN_DELAY cycles later (default 8). Back-to-back status reads that start in the cycle after the write return 1 exactly RUN_DELAY times.
- R7: A stop request issued while the settling delay is still running keeps the status bit at 1. A later run request restarts the full RUN_DELAY wait.
- R8: Bits of modules that do not exist read as 0 and ignore writes. With 376 modules these are bits 31..24 of bank 11. Writes to status addresses change nothing.
- R9: Reads of addresses that map to nothing return 0, and writes to them change no state. In the default build these are 12 to 15 and 28 to 255.
- R10: With WIDE_BANKS = 0 each bank holds 8 bits, and wdata bits 31..8 are ignored. Status addresses start at 2^ceil(log2(banks)) and read 0. clk_en still follows the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (high outside reset) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_rdata | output | 32 | Read data, 0 for writes |
| clk_en | output | NUM_MODULES | Per-module clock enable, 1 = running |

## Verification
Control readback and the response are due one edge after the request. clk_en is due at that same edge, so the bench samples both at the falling edge after the accepting edge. Status bits are due one cycle after a stop and RUN_DELAY cycles after a run. The bench tests this timing by issuing status reads back to back from the cycle after the write and counting the reads that still return 1. In the random phase it waits RUN_DELAY+2 cycles before comparing the settled status word against its own model.

// File: rtl/modstop_pkg.sv
// Shared constants, types and helpers for the module clock stop controller.
// Assumes a 32-bit register data path.
package modstop_pkg;

    localparam int unsigned WORD_W = 32;

    // Address region a request falls in
    typedef enum logic [1:0] {
        RGN_CTRL = 2'd0,
        RGN_STAT = 2'd1,
        RGN_NONE = 2'd2
    } region_e;

    // Number of banks needed to hold a module count
    function automatic int unsigned banks_for(input int unsigned mods, input int unsigned bw);
        return (mods + bw - 1) / bw;
    endfunction

endpackage

// File: rtl/modstop_gate_cell.sv
// Per-module gate handshake. The request input is the stop bit. The
// acknowledge output is the gate status: it sets one cycle after a stop
// and clears RUN_DELAY cycles after a run request. A stop during the
// settling wait aborts it. Assumes RUN_DELAY >= 1.
module modstop_gate_cell #(
    parameter int unsigned RUN_DELAY = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stop_i,
    output logic ack_o
);
    localparam int unsigned CNT_W = (RUN_DELAY > 1) ? $clog2(RUN_DELAY + 1) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(RUN_DELAY - 1);

    logic [CNT_W-1:0] cnt_q;

    // Track gate status and the settling counter after a run request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_o <= 1'b1;
            cnt_q <= '0;
        end else if (stop_i) begin
            ack_o <= 1'b1;
            cnt_q <= '0;
        end else if (ack_o) begin
            if (cnt_q == LAST) begin
                ack_o <= 1'b0;
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/modstop_regfile.sv
// Register port and stop-control storage. It decodes word addresses into
// control banks (0..NUM_BANKS-1) and status banks (STS_BASE + b). It holds
// the stop bits and answers every request one cycle later. Bits beyond
// NUM_MODULES are tied off. Assumes STS_BASE + NUM_BANKS fits in ADDR_W.
module modstop_regfile
    import modstop_pkg::*;
#(
    parameter int unsigned NUM_MODULES = 376,
    parameter int unsigned BANK_W      = 32,
    parameter bit          HAS_STATUS  = 1'b1,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [WORD_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [WORD_W-1:0]      rsp_rdata,
    output logic [NUM_MODULES-1:0] ctrl_o,
    input  logic [NUM_MODULES-1:0] sts_i
);
    localparam int unsigned NUM_BANKS = banks_for(NUM_MODULES, BANK_W);
    localparam int unsigned IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
    localparam int unsigned STS_BASE  = 1 << IDX_W;
    localparam int unsigned FLAT_W    = NUM_BANKS * BANK_W;
    localparam logic [ADDR_W-1:0] CTRL_END = ADDR_W'(NUM_BANKS);
    localparam logic [ADDR_W-1:0] STS_LO   = ADDR_W'(STS_BASE);
    localparam logic [ADDR_W-1:0] STS_END  = ADDR_W'(STS_BASE + NUM_BANKS);

    // Mask of bit positions that belong to a real module
    function automatic logic [FLAT_W-1:0] mk_exist();
        logic [FLAT_W-1:0] m;
        for (int i = 0; i < FLAT_W; i++) m[i] = (i < NUM_MODULES);
        return m;
    endfunction
    localparam logic [FLAT_W-1:0] EXIST = mk_exist();

    logic [FLAT_W-1:0]    ctrl_q;
    logic [FLAT_W-1:0]    sts_flat;
    logic [NUM_BANKS-1:0] wr_hit;
    logic [IDX_W-1:0]     bank;
    logic [WORD_W-1:0]    rd_word;
    region_e              rgn;

    // Classify the address and pick the bank index
    always_comb begin
        rgn  = RGN_NONE;
        bank = req_addr[IDX_W-1:0];
        if (req_addr < CTRL_END) begin
            rgn = RGN_CTRL;
        end else if (HAS_STATUS && (req_addr >= STS_LO) && (req_addr < STS_END)) begin
            rgn = RGN_STAT;
        end
    end

    // Widen the status vector to whole banks
    always_comb begin
        sts_flat = '0;
        sts_flat[NUM_MODULES-1:0] = sts_i;
    end

    // Per-bank write strobes and read data selection
    always_comb begin
        wr_hit  = '0;
        rd_word = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank == IDX_W'(b)) begin
                wr_hit[b] = req_valid && req_write && (rgn == RGN_CTRL);
                if (rgn == RGN_CTRL) begin
                    rd_word[BANK_W-1:0] = ctrl_q[b*BANK_W +: BANK_W];
                end else if (rgn == RGN_STAT) begin
                    rd_word[BANK_W-1:0] = sts_flat[b*BANK_W +: BANK_W];
                end
            end
        end
    end

    // Stop-control storage, all existing modules stopped at reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= EXIST;
        end else begin
            for (int b = 0; b < NUM_BANKS; b++) begin
                if (wr_hit[b]) begin
                    ctrl_q[b*BANK_W +: BANK_W] <= req_wdata[BANK_W-1:0] & EXIST[b*BANK_W +: BANK_W];
                end
            end
        end
    end

    // One-cycle response path
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_rdata <= (req_valid && !req_write) ? rd_word : '0;
        end
    end

    assign ctrl_o = ctrl_q[NUM_MODULES-1:0];

endmodule

// File: rtl/modstop_gate_ctrl.sv
// Top of the module clock stop controller. It joins the register port
// to one gate cell per module and drives the clock enables. With
// WIDE_BANKS = 0 banks are 8 bits wide and no gate cells or status view
// are built.
module modstop_gate_ctrl
    import modstop_pkg::*;
#(
    parameter int unsigned NUM_MODULES = 376,
    parameter bit          WIDE_BANKS  = 1'b1,
    parameter int unsigned RUN_DELAY   = 8,
    parameter int unsigned ADDR_W      = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [WORD_W-1:0]      req_wdata,
    output logic                   rsp_valid,
    output logic [WORD_W-1:0]      rsp_rdata,
    output logic [NUM_MODULES-1:0] clk_en
);
    localparam int unsigned BANK_W = WIDE_BANKS ? 32 : 8;

    logic [NUM_MODULES-1:0] gate_req;
    logic [NUM_MODULES-1:0] gate_ack;

    modstop_regfile #(
        .NUM_MODULES (NUM_MODULES),
        .BANK_W      (BANK_W),
        .HAS_STATUS  (WIDE_BANKS),
        .ADDR_W      (ADDR_W)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_valid (rsp_valid),
        .rsp_rdata (rsp_rdata),
        .ctrl_o    (gate_req),
        .sts_i     (gate_ack)
    );

    // One gate handshake per module, only when a status view exists
    if (WIDE_BANKS) begin : g_status
        for (genvar m = 0; m < NUM_MODULES; m++) begin : g_cell
            modstop_gate_cell #(.RUN_DELAY(RUN_DELAY)) u_cell (
                .clk    (clk),
                .rst_n  (rst_n),
                .stop_i (gate_req[m]),
                .ack_o  (gate_ack[m])
            );
        end
    end else begin : g_nostatus
        assign gate_ack = '0;
    end

    assign req_ready = rst_n;
    assign clk_en    = ~gate_req;

endmodule

// File: rtl/modstop_gate_ctrl_chk.sv
// Property checker for modstop_gate_ctrl, attached by bind. It watches
// the register port, the clock enables and the gate acknowledges. A
// small counter measures the run window of module 0.
module modstop_gate_ctrl_chk #(
    parameter int unsigned NUM_MODULES = 376,
    parameter bit          WIDE_BANKS  = 1'b1,
    parameter int unsigned RUN_DELAY   = 8,
    parameter int unsigned ADDR_W      = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   req_valid,
    input logic                   req_write,
    input logic [ADDR_W-1:0]      req_addr,
    input logic                   wdata0,
    input logic                   rsp_valid,
    input logic [NUM_MODULES-1:0] clk_en,
    input logic [NUM_MODULES-1:0] gate_ack
);
    localparam int unsigned CW = $clog2(RUN_DELAY + 2);
    localparam logic [CW-1:0] SAT = CW'(RUN_DELAY + 1);

    logic [CW-1:0] run_cnt;

    // Count consecutive cycles module 0 has been running
    always_ff @(posedge clk) begin
        if (!rst_n)           run_cnt <= '0;
        else if (!clk_en[0])  run_cnt <= '0;
        else if (run_cnt != SAT) run_cnt <= run_cnt + 1'b1;
    end

    AST_RESET_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (clk_en == '0)); // R1
    AST_RSP_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid); // R3
    AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid); // R3
    AST_BANK0_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == '0) |=> (clk_en[0] == !$past(wdata0))); // R4

    if (WIDE_BANKS) begin : g_wide
        AST_STOP_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (((~$past(clk_en)) & ~gate_ack) == '0)); // R5
        AST_FALL_WHILE_RUN: assert property (@(posedge clk) disable iff (!rst_n)
            rst_n |=> (($past(gate_ack) & ~gate_ack & ~$past(clk_en)) == '0)); // R7
        AST_RUN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(gate_ack[0]) |-> (run_cnt == CW'(RUN_DELAY))); // R6
    end

endmodule

bind modstop_gate_ctrl modstop_gate_ctrl_chk #(
    .NUM_MODULES (NUM_MODULES),
    .WIDE_BANKS  (WIDE_BANKS),
    .RUN_DELAY   (RUN_DELAY),
    .ADDR_W      (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wdata0    (req_wdata[0]),
    .rsp_valid (rsp_valid),
    .clk_en    (clk_en),
    .gate_ack  (gate_ack)
);

// File: tb/modstop_gate_ctrl_tb.sv
module modstop_gate_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NMOD  = 376;
    localparam int NBANK = 12;
    localparam int DLY   = 8;
    localparam int BMOD  = 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic        d_valid = 0, d_write = 0, d_ready, d_rsp_valid;
    logic [7:0]  d_addr = 0;
    logic [31:0] d_wdata = 0, d_rdata;
    logic [NMOD-1:0] d_clk_en;
    logic        b_valid = 0, b_write = 0, b_ready, b_rsp_valid;
    logic [7:0]  b_addr = 0;
    logic [31:0] b_wdata = 0, b_rdata;
    logic [BMOD-1:0] b_clk_en;

    int vectors = 0;
    int fails = 0;
    logic [31:0] mdl [NBANK];

    modstop_gate_ctrl #(.NUM_MODULES(NMOD), .WIDE_BANKS(1'b1), .RUN_DELAY(DLY), .ADDR_W(8)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(d_valid), .req_ready(d_ready),
        .req_write(d_write), .req_addr(d_addr), .req_wdata(d_wdata),
        .rsp_valid(d_rsp_valid), .rsp_rdata(d_rdata), .clk_en(d_clk_en));

    modstop_gate_ctrl #(.NUM_MODULES(BMOD), .WIDE_BANKS(1'b0), .RUN_DELAY(DLY), .ADDR_W(8)) u_byte (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(b_ready),
        .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
        .rsp_valid(b_rsp_valid), .rsp_rdata(b_rdata), .clk_en(b_clk_en));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] bank_mask(input int b);
        logic [31:0] m = '0;
        for (int j = 0; j < 32; j++) m[j] = (b*32 + j < NMOD);
        return m;
    endfunction

    function automatic logic [31:0] en_slice(input int b);
        logic [31:0] v = '0;
        for (int j = 0; j < 32; j++) if (b*32 + j < NMOD) v[j] = d_clk_en[b*32 + j];
        return v;
    endfunction

    // One transfer; starts and ends at a falling edge
    task automatic xfer(input bit sel, input bit wr, input logic [7:0] a,
                        input logic [31:0] wd, output logic [31:0] rd);
        if (!sel) begin d_valid = 1; d_write = wr; d_addr = a; d_wdata = wd; end
        else      begin b_valid = 1; b_write = wr; b_addr = a; b_wdata = wd; end
        @(posedge clk);
        @(negedge clk);
        if (!sel) begin d_valid = 0; rd = d_rdata; chk("R3 rsp_valid", {31'b0, d_rsp_valid}, 32'd1); end
        else      begin b_valid = 0; rd = b_rdata; chk("R3 rsp_valid", {31'b0, b_rsp_valid}, 32'd1); end
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    // Count back-to-back status reads of bank 0 bit 5 that still show 1
    task automatic count_settle(output int n);
        logic [31:0] rd;
        n = 0;
        for (int k = 0; k < 3*DLY; k++) begin
            xfer(0, 0, 8'd16, 0, rd);
            if (rd[5]) n++;
            else break;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] rd;
        int n;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int b = 0; b < NBANK; b++) begin
            mdl[b] = bank_mask(b);
            xfer(0, 0, 8'(b), 0, rd);
            chk("R1 ctrl reset", rd, bank_mask(b));
            chk("R1 clk_en reset", en_slice(b), 32'h0);
            xfer(0, 0, 8'(16 + b), 0, rd);
            chk("R1 status reset", rd, bank_mask(b));
        end

        // R9 unmapped reads
        xfer(0, 0, 8'd12, 0, rd);  chk("R9 addr 12", rd, 0);
        xfer(0, 0, 8'd15, 0, rd);  chk("R9 addr 15", rd, 0);
        xfer(0, 0, 8'd28, 0, rd);  chk("R9 addr 28", rd, 0);
        xfer(0, 0, 8'd255, 0, rd); chk("R9 addr 255", rd, 0);

        // R8 absent modules and status writes
        xfer(0, 1, 8'd11, 32'hFFFF_FFFF, rd);
        xfer(0, 0, 8'd11, 0, rd); chk("R8 absent bits ones", rd, 32'h00FF_FFFF);
        xfer(0, 1, 8'd11, 32'h0, rd); mdl[11] = 0;
        xfer(0, 0, 8'd11, 0, rd); chk("R8 absent bits zero", rd, 32'h0);
        chk("R8 clk_en bank 11", en_slice(11), 32'h00FF_FFFF);
        xfer(0, 1, 8'd16, 32'h0, rd);
        xfer(0, 0, 8'd16, 0, rd); chk("R8 status write ignored", rd, 32'hFFFF_FFFF);
        xfer(0, 0, 8'd0, 0, rd);  chk("R8 ctrl after status write", rd, 32'hFFFF_FFFF);

        // R2 mapping: module 300 is bank 9 bit 12
        mdl[9] = 32'hFFFF_EFFF;
        xfer(0, 1, 8'd9, mdl[9], rd);
        chk("R2 module 300 runs", {31'b0, d_clk_en[300]}, 1);
        chk("R2 module 299 stopped", {31'b0, d_clk_en[299]}, 0);
        chk("R2 module 301 stopped", {31'b0, d_clk_en[301]}, 0);

        // R6 run confirmation delay on bank 0 bit 5
        mdl[0] = 32'hFFFF_FFDF;
        xfer(0, 1, 8'd0, mdl[0], rd);
        chk("R4 clk_en rises at once", {31'b0, d_clk_en[5]}, 1);
        count_settle(n);
        chk("R6 settle reads", n, DLY);
        xfer(0, 0, 8'd16, 0, rd); chk("R6 status settled", rd, mdl[0]);

        // R5 stop acknowledge
        mdl[0] = 32'hFFFF_FFFF;
        xfer(0, 1, 8'd0, mdl[0], rd);
        chk("R4 clk_en falls at once", {31'b0, d_clk_en[5]}, 0);
        xfer(0, 0, 8'd16, 0, rd); chk("R5 first read", {31'b0, rd[5]}, 0);
        xfer(0, 0, 8'd16, 0, rd); chk("R5 second read", {31'b0, rd[5]}, 1);

        // R7 stop inside the settling window restarts the wait
        xfer(0, 1, 8'd0, 32'hFFFF_FFDF, rd);
        for (int k = 0; k < 3; k++) begin
            xfer(0, 0, 8'd16, 0, rd); chk("R7 still settling", {31'b0, rd[5]}, 1);
        end
        xfer(0, 1, 8'd0, 32'hFFFF_FFFF, rd);
        xfer(0, 1, 8'd0, 32'hFFFF_FFDF, rd);
        mdl[0] = 32'hFFFF_FFDF;
        count_settle(n);
        chk("R7 restarted wait", n, DLY);

        // Random phase
        for (int it = 0; it < 100; it++) begin
            if ($urandom % 8 == 0) begin
                logic [7:0] a;
                int b;
                a = ($urandom % 2 == 0) ? 8'(12 + $urandom % 4) : 8'(28 + $urandom % 228);
                xfer(0, 1, a, $urandom, rd);
                xfer(0, 0, a, 0, rd); chk("R9 unmapped random", rd, 0);
                b = $urandom % NBANK;
                xfer(0, 0, 8'(b), 0, rd); chk("R9 no side effect", rd, mdl[b]);
            end else begin
                int b;
                logic [31:0] wd;
                b = $urandom % NBANK;
                wd = $urandom;
                mdl[b] = wd & bank_mask(b);
                xfer(0, 1, 8'(b), wd, rd);
                xfer(0, 0, 8'(b), 0, rd); chk("R2 ctrl readback", rd, mdl[b]);
                chk("R4 clk_en", en_slice(b), ~mdl[b] & bank_mask(b));
                repeat (DLY + 2) @(negedge clk);
                xfer(0, 0, 8'(16 + b), 0, rd); chk("R6 settled status", rd, mdl[b]);
            end
        end

        // R10 byte-wide variant
        xfer(1, 0, 8'd0, 0, rd); chk("R10 reset bank 0", rd, 32'hFF);
        xfer(1, 0, 8'd2, 0, rd); chk("R10 reset bank 2", rd, 32'h0F);
        xfer(1, 0, 8'd4, 0, rd); chk("R10 no status", rd, 32'h0);
        xfer(1, 1, 8'd1, 32'hFFFF_FF5A, rd);
        xfer(1, 0, 8'd1, 0, rd); chk("R10 readback", rd, 32'h5A);
        chk("R10 clk_en", {24'b0, b_clk_en[15:8]}, 32'hA5);
        xfer(1, 1, 8'd2, 32'h0, rd);
        chk("R10 clk_en bank 2", {28'b0, b_clk_en[19:16]}, 32'hF);
        xfer(1, 1, 8'd4, 32'h0, rd);
        xfer(1, 0, 8'd0, 0, rd); chk("R10 status write ignored", rd, 32'hFF);

        finish_run();
    end

endmodule